// File: doc/BRIEF.md
# Autonomous Limit Monitor with Alert Confirmation

This block runs the monitoring loop of a multi-channel data acquisition front end, with no host involved. Once started, it requests conversions either on one fixed channel or round-robin over every channel. It checks each result against that channel's lower and upper limit words. The limit words come from an external register store, which looks them up by the channel number the block presents.

When a result falls in the channel's alert region, the block stops scanning and keeps converting that same channel. The alert is confirmed only by a run of consecutive failing results. On confirmation the block drives its active-low alert, latches the offending channel and stops. It stays stopped until the host halts it, which also clears the alert.

The converter handshake is level based. The block holds a request with a channel number. The converter returns a one-cycle done strobe together with the result. The block uses that result on the clock edge where done is high.

Top module: `lim_mon_top`

## Requirements
- R1: After reset, alert_no is 1, running_o is 0, conv_req_o is 0 and alert_ch_o is 0.
- R2: A start_i pulse while no alert is pending makes running_o and conv_req_o 1 on the next edge. In fixed mode (scan_i=0) conv_ch_o becomes chan_i, or 0 if chan_i is not below NUM_CH. In scan mode (scan_i=1) it becomes 0.
- R3: In scan mode, each in-region result advances conv_ch_o by one, wrapping from NUM_CH-1 to 0. In fixed mode the channel never changes.
- R4: The option pair is {bit 10 of upper word, bit 10 of lower word}, with data in bits 9:0. Pair 00 alerts when x < lower or x > upper.
- R5: Pair 01 alerts when x <= lower or x >= upper.
- R6: Pair 10 alerts when x <= lower or x > upper. For example, with lower 199h and upper 266h, the results 199h and 267h alert and the results 19Ah and 266h do not.
- R7: Pair 11 alerts when lower <= x <= upper. A lower limit above the upper limit therefore never alerts.
- R8: An alerting result holds conv_ch_o on the same channel, also in scan mode.
- R9: The edge that takes the CONFIRM_N-th consecutive alerting result of a channel drives alert_no to 0, latches that channel on alert_ch_o, and clears running_o and conv_req_o.
- R10: An in-region result resets the consecutive count, and scanning resumes from the next channel.
- R11: halt_i stops monitoring on the next edge. It also sets alert_no to 1 and alert_ch_o to 0, and it takes priority over start_i.
- R12: start_i has no effect while an alert is pending.
- R13: A start_i pulse while running restarts the loop with a zero count, and discards a result that arrives on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or restart monitoring |
| scan_i | input | 1 | 1 = scan all channels, 0 = fixed channel |
| chan_i | input | CH_W | Fixed channel index |
| halt_i | input | 1 | Host read: halt and clear alert |
| conv_req_o | output | 1 | Conversion request |
| conv_ch_o | output | CH_W | Channel to convert and whose limits are looked up |
| conv_done_i | input | 1 | Conversion result valid strobe |
| conv_data_i | input | DATA_W | Conversion result |
| lim_lo_i | input | DATA_W+1 | Lower limit word of conv_ch_o, MSB is option bit |
| lim_hi_i | input | DATA_W+1 | Upper limit word of conv_ch_o, MSB is option bit |
| alert_no | output | 1 | Alert, active low |
| alert_ch_o | output | CH_W | Latched offending channel |
| running_o | output | 1 | Monitoring active |

## Verification
The bench builds the block with its defaults: three channels, 10-bit data and a confirmation count of five. The scan wrap from channel 2 to 0 and the full five-result confirmation window are therefore exercised exactly. A behavioural model runs beside the design and is compared every clock. The scenarios cover every option pair at both limits, an inverted limit pair, an in-region result that interrupts a confirmation run, a restart partway through a run, and an alert raised during scanning.

// File: rtl/lim_mon_pkg.sv
package lim_mon_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ALERT} mon_state_e;
  // option pair {upper opt, lower opt}
  localparam logic [1:0] OPT_OUT_STRICT = 2'b00;
  localparam logic [1:0] OPT_OUT_INCL   = 2'b01;
  localparam logic [1:0] OPT_OUT_LO_EQ  = 2'b10;
  localparam logic [1:0] OPT_IN_INCL    = 2'b11;
endpackage

// File: rtl/lim_region_eval.sv
module lim_region_eval
  import lim_mon_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [DATA_W:0]   lo_i,
  input  logic [DATA_W:0]   hi_i,
  output logic              out_o
);
  logic [1:0]        opt;
  logic [DATA_W-1:0] lo, hi;

  assign opt = {hi_i[DATA_W], lo_i[DATA_W]};
  assign lo  = lo_i[DATA_W-1:0];
  assign hi  = hi_i[DATA_W-1:0];

  always_comb begin
    unique case (opt)
      OPT_OUT_STRICT: out_o = (val_i <  lo) || (val_i >  hi);
      OPT_OUT_INCL:   out_o = (val_i <= lo) || (val_i >= hi);
      OPT_OUT_LO_EQ:  out_o = (val_i <= lo) || (val_i >  hi);
      default:        out_o = (val_i >= lo) && (val_i <= hi);
    endcase
  end
endmodule

// File: rtl/chan_ptr.sv
module chan_ptr #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CH_W-1:0] load_ch_i,
  input  logic            adv_i,
  output logic [CH_W-1:0] ch_o
);
  logic [CH_W-1:0] ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ch_q <= '0;
    else if (load_i) ch_q <= load_ch_i;
    else if (adv_i)  ch_q <= (ch_q == CH_W'(NUM_CH-1)) ? '0 : ch_q + 1'b1;
  end

  assign ch_o = ch_q;

  AST_CH_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ch_q) < NUM_CH); // R3
endmodule

// File: rtl/confirm_cnt.sv
module confirm_cnt #(
  parameter int CONFIRM_N = 5,
  parameter int CNT_W     = (CONFIRM_N > 1) ? $clog2(CONFIRM_N) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = inc_i && (cnt_q == CNT_W'(CONFIRM_N-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < CONFIRM_N); // R9
endmodule

// File: rtl/lim_mon_top.sv
module lim_mon_top
  import lim_mon_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int DATA_W    = 10,
  parameter int CONFIRM_N = 5,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              scan_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              halt_i,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic [DATA_W:0]   lim_lo_i,
  input  logic [DATA_W:0]   lim_hi_i,
  output logic              alert_no,
  output logic [CH_W-1:0]   alert_ch_o,
  output logic              running_o
);
  mon_state_e      state_q;
  logic            scan_q;
  logic [CH_W-1:0] alert_ch_q, ch, load_ch;
  logic            start_ok, res_ev, out, inc, hit, cnt_clr, adv;

  assign start_ok = start_i && !halt_i && (state_q != ST_ALERT);
  // restart and halt both win over a result on the same edge
  assign res_ev   = (state_q == ST_RUN) && conv_done_i && !halt_i && !start_i;
  assign inc      = res_ev && out;
  assign cnt_clr  = halt_i || start_ok || (res_ev && !out);
  assign adv      = res_ev && !out && scan_q;
  assign load_ch  = (scan_i || 32'(chan_i) >= NUM_CH) ? '0 : chan_i;

  lim_region_eval #(.DATA_W(DATA_W)) u_eval (
    .val_i(conv_data_i), .lo_i(lim_lo_i), .hi_i(lim_hi_i), .out_o(out)
  );

  chan_ptr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ptr (
    .clk_i, .rst_ni, .load_i(start_ok), .load_ch_i(load_ch), .adv_i(adv), .ch_o(ch)
  );

  confirm_cnt #(.CONFIRM_N(CONFIRM_N)) u_cnt (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(inc), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      scan_q     <= 1'b0;
      alert_ch_q <= '0;
    end else if (halt_i) begin
      state_q    <= ST_IDLE;
      alert_ch_q <= '0;
    end else if (start_ok) begin
      state_q    <= ST_RUN;
      scan_q     <= scan_i;
    end else if (hit) begin
      state_q    <= ST_ALERT;
      alert_ch_q <= ch;
    end
  end

  assign conv_req_o = (state_q == ST_RUN);
  assign running_o  = (state_q == ST_RUN);
  assign conv_ch_o  = ch;
  assign alert_no   = (state_q != ST_ALERT);
  assign alert_ch_o = alert_ch_q;

  AST_ALERT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_no |-> (!running_o && !conv_req_o)); // R9
  AST_HALT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (alert_no && !running_o && alert_ch_o == '0)); // R11
  AST_HOLD_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && conv_done_i && !halt_i && !start_i && out) |=> (conv_ch_o == $past(conv_ch_o))); // R8
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_no && start_i && !halt_i) |=> !alert_no); // R12
  AST_SCAN_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && conv_done_i && !halt_i && !start_i && !out && scan_q && NUM_CH > 1)
      |=> (conv_ch_o != $past(conv_ch_o))); // R3
endmodule

// File: tb/tb_lim_mon_top.sv
module tb_lim_mon_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int DW  = 10;
  localparam int CW  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, scan_i = 0, halt_i = 0, auto_conv = 0;
  logic [CW-1:0] chan_i = '0;
  logic conv_req_o, conv_done_i, alert_no, running_o;
  logic [CW-1:0] conv_ch_o, alert_ch_o;
  logic [DW-1:0] conv_data_i;
  logic [DW:0] lim_lo_i, lim_hi_i;
  logic [DW:0] lo_arr [NCH];
  logic [DW:0] hi_arr [NCH];
  logic [DW-1:0] data_v [NCH];

  int checks = 0, failures = 0, cyc_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // register store and converter stand-ins
  assign lim_lo_i    = lo_arr[conv_ch_o];
  assign lim_hi_i    = hi_arr[conv_ch_o];
  assign conv_done_i = auto_conv && conv_req_o;
  assign conv_data_i = data_v[conv_ch_o];

  lim_mon_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .scan_i, .chan_i, .halt_i,
    .conv_req_o, .conv_ch_o, .conv_done_i, .conv_data_i,
    .lim_lo_i, .lim_hi_i, .alert_no, .alert_ch_o, .running_o
  );

  // behavioural reference
  bit m_run, m_scan, m_alert;
  int m_ch, m_cnt, m_ach;

  function automatic bit m_out(int v, logic [DW:0] lw, logic [DW:0] hw);
    int l = int'(lw[DW-1:0]);
    int h = int'(hw[DW-1:0]);
    bit ol = lw[DW], oh = hw[DW];
    bit below, above;
    if (ol && oh) return (v >= l) && (v <= h);
    below = (ol || oh) ? (v <= l) : (v < l);
    above = (ol && !oh) ? (v >= h) : (v > h);
    return below || above;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_scan = 0; m_alert = 0; m_ch = 0; m_cnt = 0; m_ach = 0;
    end else if (halt_i) begin
      m_run = 0; m_alert = 0; m_ach = 0; m_cnt = 0;
    end else if (start_i && !m_alert) begin
      m_run = 1; m_scan = scan_i; m_cnt = 0;
      m_ch = (scan_i || chan_i >= NCH) ? 0 : int'(chan_i);
    end else if (m_run && conv_done_i) begin
      if (m_out(int'(data_v[m_ch]), lo_arr[m_ch], hi_arr[m_ch])) begin
        m_cnt++;
        if (m_cnt == 5) begin
          m_alert = 1; m_ach = m_ch; m_run = 0; m_cnt = 0;
        end
      end else begin
        m_cnt = 0;
        if (m_scan) m_ch = (m_ch + 1) % NCH;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R3 model alert_no", int'(alert_no), int'(!m_alert));
    chk("R9 model alert_ch", int'(alert_ch_o), m_ach);
    chk("R2 model running", int'(running_o), int'(m_run));
    chk("R2 model req", int'(conv_req_o), int'(m_run));
    chk("R8 model ch", int'(conv_ch_o), m_ch);
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_mon(bit s, int ch);
    start_i = 1; scan_i = s; chan_i = CW'(ch);
    cyc(1);
    start_i = 0;
  endtask

  task automatic halt();
    halt_i = 1; cyc(1); halt_i = 0;
  endtask

  task automatic region_case(int ch, int val, bit exp_alert, string tag);
    data_v[ch] = DW'(val);
    start_mon(0, ch);
    cyc(6);
    chk(tag, int'(alert_no), int'(!exp_alert));
    halt();
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc_cnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    lo_arr[0] = {1'b0, 10'h199}; hi_arr[0] = {1'b1, 10'h266};
    lo_arr[1] = {1'b0, 10'd100}; hi_arr[1] = {1'b0, 10'd200};
    lo_arr[2] = {1'b1, 10'd300}; hi_arr[2] = {1'b1, 10'd200};
    data_v[0] = 10'h200; data_v[1] = 10'd150; data_v[2] = 10'd250;
    cyc(3);
    chk("R1 alert_no", int'(alert_no), 1);
    chk("R1 running", int'(running_o), 0);
    chk("R1 req", int'(conv_req_o), 0);
    chk("R1 alert_ch", int'(alert_ch_o), 0);
    rst_n = 1;
    cyc(1);
    auto_conv = 1;

    // fixed channel, in-region
    start_mon(0, 1);
    chk("R2 running", int'(running_o), 1);
    chk("R2 fixed ch", int'(conv_ch_o), 1);
    cyc(8);
    chk("R3 fixed stays", int'(conv_ch_o), 1);
    chk("R3 no alert", int'(alert_no), 1);
    halt();
    chk("R11 halted", int'(running_o), 0);

    // out-of-range fixed index
    start_mon(0, 3);
    chk("R2 clamp ch", int'(conv_ch_o), 0);
    halt();

    // scan order
    start_mon(1, 2);
    chk("R2 scan ch0", int'(conv_ch_o), 0);
    for (int i = 1; i <= 4; i++) begin
      cyc(1);
      chk("R3 scan order", int'(conv_ch_o), i % NCH);
    end
    halt();

    // option 10 example
    region_case(0, 'h199, 1, "R6 at lower");
    region_case(0, 'h19A, 0, "R6 above lower");
    region_case(0, 'h266, 0, "R6 at upper");
    region_case(0, 'h267, 1, "R6 above upper");
    // option 00
    region_case(1, 100, 0, "R4 at lower");
    region_case(1, 99,  1, "R4 below lower");
    region_case(1, 200, 0, "R4 at upper");
    region_case(1, 201, 1, "R4 above upper");
    // option 01
    lo_arr[1] = {1'b1, 10'd100};
    region_case(1, 100, 1, "R5 at lower");
    region_case(1, 200, 1, "R5 at upper");
    region_case(1, 101, 0, "R5 inside");
    // option 11, inverted then normal
    region_case(2, 250,  0, "R7 inverted mid");
    region_case(2, 0,    0, "R7 inverted low");
    region_case(2, 1023, 0, "R7 inverted high");
    lo_arr[2] = {1'b1, 10'd200}; hi_arr[2] = {1'b1, 10'd300};
    region_case(2, 200, 1, "R7 at lower");
    region_case(2, 300, 1, "R7 at upper");
    region_case(2, 199, 0, "R7 below");
    data_v[2] = 10'd100;

    // exact confirmation timing
    data_v[0] = 10'h100;
    start_mon(0, 0);
    cyc(4);
    chk("R9 four results", int'(alert_no), 1);
    cyc(1);
    chk("R9 fifth result", int'(alert_no), 0);
    chk("R9 alert ch", int'(alert_ch_o), 0);
    chk("R9 stopped", int'(running_o), 0);
    start_mon(0, 1);
    chk("R12 start ignored", int'(alert_no), 0);
    chk("R12 still stopped", int'(running_o), 0);
    halt();
    chk("R11 alert cleared", int'(alert_no), 1);
    chk("R11 ch cleared", int'(alert_ch_o), 0);

    // interrupted confirmation
    start_mon(0, 0);
    cyc(3);
    data_v[0] = 10'h200;
    cyc(1);
    data_v[0] = 10'h100;
    cyc(4);
    chk("R10 count reset", int'(alert_no), 1);
    cyc(1);
    chk("R10 then alert", int'(alert_no), 0);
    halt();

    // restart mid-run
    start_mon(0, 0);
    cyc(3);
    start_mon(0, 0);
    cyc(4);
    chk("R13 restart resets", int'(alert_no), 1);
    cyc(1);
    chk("R13 then alert", int'(alert_no), 0);
    halt();
    data_v[0] = 10'h200;

    // scan-mode alert on channel 1, then recovery
    lo_arr[1] = {1'b0, 10'd100};
    data_v[1] = 10'd50;
    start_mon(1, 0);
    cyc(3);
    chk("R8 held ch1", int'(conv_ch_o), 1);
    data_v[1] = 10'd150;
    cyc(1);
    chk("R10 resume scan", int'(conv_ch_o), 2);
    data_v[1] = 10'd50;
    cyc(8);
    chk("R9 scan alert", int'(alert_no), 0);
    chk("R9 scan alert ch", int'(alert_ch_o), 1);
    halt();

    // halt over start
    start_mon(1, 0);
    data_v[1] = 10'd150;
    start_i = 1; halt_i = 1;
    cyc(1);
    start_i = 0; halt_i = 0;
    chk("R11 halt priority", int'(running_o), 0);
    cyc(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule